// File: doc/BRIEF.md
# Load-Reserved Reservation Monitor

This block tracks the load-reserved reservation of a single hart and decides whether a later store-conditional from that hart succeeds. A load-reserved request records a naturally aligned block of memory that contains every byte of the access. A store-conditional succeeds only when that reservation is still live and the store lies wholly inside the block. Every store-conditional ends the reservation, whatever its outcome.

The reservation is lost when another agent writes into the block. The snoop port reports remote plain stores, atomic read-modify-writes and remote successful store-conditionals, and each of these cancels it. Remote loads and remote load-reserved requests leave it alone. A trap (interrupt or synchronous exception) also cancels it. Software can read the block base and its size as a power of two at any time. The size is clamped so that the block never exceeds the configured page.

Top module: `lr_resv_monitor`

## Requirements
- R1: After reset, `resv_valid` and `sc_resp_valid` are 0.
- R2: An LR reserves the naturally aligned block of 2^`resv_shift` bytes that holds its first byte. `resv_base` becomes the LR address with its low `resv_shift` bits cleared, and `resv_valid` becomes 1. Size codes are 0, 1, 2 and 3, for 1, 2, 4 and 8 bytes.
- R3: An LR whose bytes cross a block boundary leaves no reservation (`resv_valid` is 0 afterwards).
- R4: An SC succeeds (`sc_fail`=0) only if the reservation is valid and every byte of the SC lies in the reserved block. This holds for any address and size inside the block. Otherwise `sc_fail`=1.
- R5: Every SC clears the reservation, so a second SC without a new LR fails. An SC outside the block clears it as well.
- R6: A snoop of kind 2 (remote store or AMO) or kind 3 (remote successful SC) that overlaps any byte of the block clears the reservation. A snoop outside the block has no effect.
- R7: Snoops of kind 0 (remote load) and kind 1 (remote LR) never affect the reservation.
- R8: `irq_take` or `exc_take` clears the reservation. Either one in the same cycle as an LR cancels that LR.
- R9: `sc_resp_valid` is high for exactly the one cycle after each SC request, and `sc_fail` is valid with it.
- R10: An SC in the same cycle as a clearing snoop or a trap fails.
- R11: `resv_shift` equals log2 of RES_BYTES, clamped between 3 and log2 of PAGE_BYTES. By default it is 6.
- R12: If an LR and an SC arrive in the same cycle, the SC is handled and the LR is dropped.
- R13: A new LR replaces any earlier reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lr_valid | input | 1 | Local load-reserved request |
| lr_addr | input | ADDR_W | LR byte address |
| lr_size | input | 2 | LR size code (log2 bytes) |
| sc_valid | input | 1 | Local store-conditional request |
| sc_addr | input | ADDR_W | SC byte address |
| sc_size | input | 2 | SC size code (log2 bytes) |
| snp_valid | input | 1 | Remote access observed |
| snp_kind | input | 2 | 0 load, 1 LR, 2 store/AMO, 3 successful SC |
| snp_addr | input | ADDR_W | Remote access address |
| snp_size | input | 2 | Remote access size code |
| irq_take | input | 1 | Interrupt taken by the hart |
| exc_take | input | 1 | Synchronous exception raised |
| sc_resp_valid | output | 1 | SC result strobe |
| sc_fail | output | 1 | 0 success, 1 failure |
| resv_valid | output | 1 | Reservation live |
| resv_base | output | ADDR_W | Reserved block base address |
| resv_shift | output | 6 | log2 of reserved block size |

## Verification
Every request is sampled at one rising edge, and its results appear after that same edge. The SC result and the reservation state are both visible one cycle after the request. The bench drives each request on a falling edge and holds it for one cycle. It then reads `resv_valid` and `resv_base` on the next falling edge, which is half a cycle after the register update. A scoreboard queues the expected SC outcome when the SC is driven. A falling-edge monitor pops that entry when `sc_resp_valid` appears and flags any strobe that arrives without a queued entry, which holds the result to the one-cycle latency.

// File: rtl/rsvmon_pkg.sv
package rsvmon_pkg;
  typedef enum logic [1:0] {
    SNP_LOAD  = 2'd0,
    SNP_LR    = 2'd1,
    SNP_STORE = 2'd2,
    SNP_SCOK  = 2'd3
  } snoop_kind_e;

  function automatic int clamp_shift(input int res_lg, input int page_lg);
    int v;
    v = res_lg;
    if (v < 3) v = 3;
    if (v > page_lg) v = page_lg;
    return v;
  endfunction
endpackage

// File: rtl/rsvmon_span.sv
module rsvmon_span #(
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 6,
  parameter bit OVERLAP = 1'b0,
  localparam int BW     = ADDR_W - GRAN_LG
) (
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [BW-1:0]     ref_blk,
  output logic              hit
);
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] last_addr;
  logic              first_eq;
  logic              last_eq;

  always_comb begin
    span      = ADDR_W'({acc_size == 2'd3, acc_size[1], |acc_size});
    last_addr = acc_addr + span;
    first_eq  = (acc_addr[ADDR_W-1:GRAN_LG] == ref_blk);
    last_eq   = (last_addr[ADDR_W-1:GRAN_LG] == ref_blk);
  end

  generate
    if (OVERLAP) begin : g_overlap
      assign hit = first_eq | last_eq;
    end else begin : g_contain
      assign hit = first_eq & last_eq;
    end
  endgenerate
endmodule

// File: rtl/rsvmon_state.sv
module rsvmon_state #(
  parameter int ADDR_W  = 32,
  parameter int GRAN_LG = 6,
  localparam int BW     = ADDR_W - GRAN_LG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lr_valid,
  input  logic          lr_fits,
  input  logic [BW-1:0] lr_blk,
  input  logic          sc_valid,
  input  logic          sc_inside,
  input  logic          snp_kill,
  input  logic          trap,
  output logic          resv_valid,
  output logic [BW-1:0] resv_blk,
  output logic          sc_resp_valid,
  output logic          sc_fail
);
  logic          valid_q, valid_d;
  logic [BW-1:0] blk_q;
  logic          blk_en;
  logic          resp_q;
  logic          fail_q, fail_d;
  logic          kill;

  always_comb begin
    kill    = trap | snp_kill;
    valid_d = valid_q;
    fail_d  = fail_q;
    blk_en  = 1'b0;
    if (sc_valid) begin
      fail_d  = ~(valid_q & sc_inside & ~kill);
      valid_d = 1'b0;
    end else if (lr_valid) begin
      blk_en  = 1'b1;
      valid_d = lr_fits & ~trap;
    end else if (kill) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      resp_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      resp_q  <= sc_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      fail_q <= 1'b1;
    end else begin
      if (blk_en)   blk_q  <= lr_blk;
      if (sc_valid) fail_q <= fail_d;
    end
  end

  assign resv_valid    = valid_q;
  assign resv_blk      = blk_q;
  assign sc_resp_valid = resp_q;
  assign sc_fail       = fail_q;

  // R9
  sc_rsp_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |=> sc_resp_valid);
  // R9
  sc_rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_valid |=> !sc_resp_valid);
  // R5
  sc_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_valid |=> !resv_valid);
  // R8
  trap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !resv_valid);
  // R4
  sc_ok_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_resp_valid && !sc_fail) |-> $past(resv_valid));
  // R7
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sc_valid && !lr_valid && !kill) |=> $stable(resv_valid));
endmodule

// File: rtl/lr_resv_monitor.sv
module lr_resv_monitor
  import rsvmon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int RES_BYTES  = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lr_valid,
  input  logic [ADDR_W-1:0] lr_addr,
  input  logic [1:0]        lr_size,
  input  logic              sc_valid,
  input  logic [ADDR_W-1:0] sc_addr,
  input  logic [1:0]        sc_size,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_size,
  input  logic              irq_take,
  input  logic              exc_take,
  output logic              sc_resp_valid,
  output logic              sc_fail,
  output logic              resv_valid,
  output logic [ADDR_W-1:0] resv_base,
  output logic [5:0]        resv_shift
);
  localparam int GRAN_LG = clamp_shift($clog2(RES_BYTES), $clog2(PAGE_BYTES));
  localparam int BW      = ADDR_W - GRAN_LG;

  logic [BW-1:0] lr_blk;
  logic [BW-1:0] held_blk;
  logic          lr_fits;
  logic          sc_inside;
  logic          snp_hit;
  logic          snp_kill;
  logic          snp_writes;

  assign lr_blk = lr_addr[ADDR_W-1:GRAN_LG];

  rsvmon_span #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .OVERLAP(1'b0)) u_lr_span (
    .acc_addr(lr_addr), .acc_size(lr_size), .ref_blk(lr_blk), .hit(lr_fits));

  rsvmon_span #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .OVERLAP(1'b0)) u_sc_span (
    .acc_addr(sc_addr), .acc_size(sc_size), .ref_blk(held_blk), .hit(sc_inside));

  rsvmon_span #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG), .OVERLAP(1'b1)) u_snp_span (
    .acc_addr(snp_addr), .acc_size(snp_size), .ref_blk(held_blk), .hit(snp_hit));

  always_comb begin
    snp_writes = (snoop_kind_e'(snp_kind) == SNP_STORE) ||
                 (snoop_kind_e'(snp_kind) == SNP_SCOK);
    snp_kill   = snp_valid & snp_writes & snp_hit;
  end

  rsvmon_state #(.ADDR_W(ADDR_W), .GRAN_LG(GRAN_LG)) u_state (
    .clk(clk), .rst_n(rst_n),
    .lr_valid(lr_valid), .lr_fits(lr_fits), .lr_blk(lr_blk),
    .sc_valid(sc_valid), .sc_inside(sc_inside),
    .snp_kill(snp_kill), .trap(irq_take | exc_take),
    .resv_valid(resv_valid), .resv_blk(held_blk),
    .sc_resp_valid(sc_resp_valid), .sc_fail(sc_fail));

  assign resv_base  = {held_blk, {GRAN_LG{1'b0}}};
  assign resv_shift = 6'(GRAN_LG);

  // R6
  snoop_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_kind[1] && snp_hit && !lr_valid) |=> !resv_valid);
  // R3
  straddle_lr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_valid && !sc_valid && !lr_fits) |=> !resv_valid);
endmodule

// File: tb/lr_resv_monitor_test.sv
module lr_resv_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lr_valid, sc_valid, snp_valid, irq_take, exc_take;
  logic [31:0] lr_addr, sc_addr, snp_addr;
  logic [1:0]  lr_size, sc_size, snp_kind, snp_size;
  logic        sc_resp_valid, sc_fail, resv_valid;
  logic [31:0] resv_base;
  logic [5:0]  resv_shift;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  lr_resv_monitor uut (
    .clk(clk), .rst_n(rst_n),
    .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_size(lr_size),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_size(sc_size),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_size(snp_size),
    .irq_take(irq_take), .exc_take(exc_take),
    .sc_resp_valid(sc_resp_valid), .sc_fail(sc_fail),
    .resv_valid(resv_valid), .resv_base(resv_base), .resv_shift(resv_shift));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected SC result per response strobe (R9).
  always @(negedge clk) begin
    if (rst_n && sc_resp_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R9: actual unexpected strobe expected none");
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, 32'(sc_fail), 32'(e));
      end
    end
  end

  task automatic cyc(input bit dl, input logic [31:0] la, input logic [1:0] ls,
                     input bit ds, input logic [31:0] sa, input logic [1:0] ss,
                     input bit sexp, input string stag,
                     input bit dn, input logic [1:0] nk, input logic [31:0] na,
                     input logic [1:0] ns, input bit ti, input bit te);
    @(negedge clk);
    if (ds) begin exp_q.push_back(sexp); tag_q.push_back(stag); end
    lr_valid = dl; lr_addr = la; lr_size = ls;
    sc_valid = ds; sc_addr = sa; sc_size = ss;
    snp_valid = dn; snp_kind = nk; snp_addr = na; snp_size = ns;
    irq_take = ti; exc_take = te;
    @(negedge clk);
    lr_valid = 0; sc_valid = 0; snp_valid = 0; irq_take = 0; exc_take = 0;
  endtask

  task automatic lr(input logic [31:0] a, input logic [1:0] s);
    cyc(1, a, s, 0, 0, 0, 0, "", 0, 0, 0, 0, 0, 0);
  endtask
  task automatic sc(input logic [31:0] a, input logic [1:0] s, input bit e, input string t);
    cyc(0, 0, 0, 1, a, s, e, t, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic snoop(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
    cyc(0, 0, 0, 0, 0, 0, 0, "", 1, k, a, s, 0, 0);
  endtask

  bit timed_out = 0;
  initial begin
    repeat (200000) @(posedge clk);
    timed_out = 1;
  end

  initial begin
    rst_n = 0;
    lr_valid = 0; sc_valid = 0; snp_valid = 0; irq_take = 0; exc_take = 0;
    lr_addr = 0; sc_addr = 0; snp_addr = 0;
    lr_size = 0; sc_size = 0; snp_kind = 0; snp_size = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", 32'(resv_valid), 0);
    chk("R1 resp", 32'(sc_resp_valid), 0);
    chk("R11 shift", 32'(resv_shift), 6);

    lr(32'h1234, 2);
    chk("R2 valid", 32'(resv_valid), 1);
    chk("R2 base", resv_base, 32'h1200);
    sc(32'h1234, 2, 0, "R4 same addr");
    chk("R5 cleared", 32'(resv_valid), 0);
    sc(32'h1234, 2, 1, "R5 second sc");

    lr(32'h1204, 2);
    sc(32'h1238, 3, 0, "R4 other addr in block");

    lr(32'h1200, 3);
    sc(32'h1240, 2, 1, "R4 outside block");
    chk("R5 scratch clears", 32'(resv_valid), 0);

    lr(32'h1000, 2);
    lr(32'h103C, 3);
    chk("R3 straddle", 32'(resv_valid), 0);
    sc(32'h1000, 2, 1, "R3 sc after straddle");

    lr(32'h2000, 2);
    snoop(2, 32'h2040, 2);
    chk("R6 outside snoop", 32'(resv_valid), 1);
    snoop(0, 32'h2000, 2);
    snoop(1, 32'h2004, 2);
    chk("R7 load/lr snoop", 32'(resv_valid), 1);
    sc(32'h2000, 2, 0, "R7 sc after benign snoops");

    lr(32'h2000, 2);
    snoop(2, 32'h2010, 2);
    chk("R6 store snoop", 32'(resv_valid), 0);
    sc(32'h2000, 2, 1, "R6 sc after store");

    lr(32'h4000, 2);
    snoop(3, 32'h3FFC, 3);
    chk("R6 remote sc overlap", 32'(resv_valid), 0);

    lr(32'h5000, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, "", 0, 0, 0, 0, 1, 0);
    chk("R8 irq", 32'(resv_valid), 0);
    lr(32'h5000, 2);
    cyc(0, 0, 0, 0, 0, 0, 0, "", 0, 0, 0, 0, 0, 1);
    chk("R8 exc", 32'(resv_valid), 0);
    cyc(1, 32'h5000, 2, 0, 0, 0, 0, "", 0, 0, 0, 0, 1, 0);
    chk("R8 lr with irq", 32'(resv_valid), 0);

    lr(32'h6000, 2);
    cyc(0, 0, 0, 1, 32'h6000, 2, 1, "R10 sc with store", 1, 2, 32'h6008, 2, 0, 0);
    lr(32'h6000, 2);
    cyc(0, 0, 0, 1, 32'h6000, 2, 1, "R10 sc with irq", 0, 0, 0, 0, 1, 0);

    lr(32'h7000, 2);
    lr(32'h8010, 2);
    chk("R13 new base", resv_base, 32'h8000);
    sc(32'h7000, 2, 1, "R13 old block");

    cyc(1, 32'h9000, 2, 1, 32'h9000, 2, 1, "R12 lr+sc", 0, 0, 0, 0, 0, 0);
    chk("R12 lr dropped", 32'(resv_valid), 0);
    chk("R12 base kept", resv_base, 32'h8000);

    @(negedge clk);
    chk("R9 no stray", 32'(sc_resp_valid), 0);
    chk("R9 queue drained", 32'(exp_q.size()), 0);
    finish_run();
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge timed_out) begin
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule